// File: doc/BRIEF.md
# Packed Signed Word Dot-Product Accumulator

This block is a vector datapath for a 512-bit register file. The vector is split into 32-bit lanes. In each lane, two adjacent signed 16-bit words of the first source are multiplied by the two matching signed words of the second source. Both products are added to the lane's old accumulator value, and the 32-bit sum is written back. The sum wraps modulo 2^32. There is no saturation and no overflow flag.

The block has three controls. A vector-length select sets how many lanes are active; every bit above that length is cleared. A per-lane mask, when enabled, either zeroes or preserves the lanes whose mask bit is clear. A broadcast flag makes every lane read the lowest 32-bit element of the second source instead of its own element.

The result is registered. It appears one cycle after an input strobe, together with an output valid flag.

Top module: `dpacc_top`

## Requirements
- R1: In lane i, word 2i of `src_a` (bits 32i+15..32i) is multiplied as a signed value by the low word of the lane's second operand. Word 2i+1 (bits 32i+31..32i+16) is multiplied by the high word.
- R2: An active, updated lane becomes its `acc_in` lane plus both products, truncated to 32 bits (wraps modulo 2^32). Example: an accumulator of 0x7FFF0000 plus two products of (-32768)*(-32768) gives 0xFFFF0000.
- R3: `vlen_sel` code 0 gives 4 active lanes (128 bits). Code 1 gives 8 lanes (256 bits). Code 2 gives 16 lanes (512 bits). Code 3 behaves like code 2.
- R4: Every result lane at or above the active lane count is zero, whatever the inputs.
- R5: When `mask_on` is 1 and `zero_mode` is 1, an active lane whose `lane_mask` bit is 0 becomes zero.
- R6: When `mask_on` is 1 and `zero_mode` is 0, an active lane whose `lane_mask` bit is 0 keeps its `acc_in` value.
- R7: When `mask_on` is 0, `lane_mask` and `zero_mode` have no effect and every active lane is updated.
- R8: When `bcast` is 1, every lane uses `src_b[31:0]` as its second operand. Bits 15..0 pair with word 2i and bits 31..16 with word 2i+1. The other bits of `src_b` are ignored.
- R9: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` at 1. `result` changes only after a strobe and otherwise holds its value.
- R10: While reset is active and until the first strobe, `out_valid` is 0 and `result` is all zeros. Reset is asynchronous and active-low, and its release is synchronised internally over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; operands are captured on this edge |
| src_a | input | 512 | First source, 32 signed 16-bit words |
| src_b | input | 512 | Second source, 32 signed 16-bit words |
| acc_in | input | 512 | Original destination, 16 lanes of 32 bits |
| vlen_sel | input | 2 | Active vector length code |
| lane_mask | input | 16 | Per-lane write mask |
| mask_on | input | 1 | Enables the lane mask |
| zero_mode | input | 1 | 1: masked lanes are cleared, 0: masked lanes are kept |
| bcast | input | 1 | Use the lowest 32-bit element of `src_b` in every lane |
| out_valid | output | 1 | Result is valid |
| result | output | 512 | New destination vector |

## Verification
The in-line properties assume that every input is known, and stable at each edge where `in_valid` is sampled high. They compare a lane only against values captured in the same strobe cycle, and they are meaningful only once the internal reset has been released. The stimulus meets these conditions in four ways:
- It drives all inputs at the falling edge.
- It holds `in_valid` low until reset has fully released.
- It draws `vlen_sel` over all four codes, including the alias code 3.
- It draws masks from full, empty and random patterns, and mixes in directed vectors for the extreme product corner and for inputs that change while the strobe is low.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;

  // Per-lane action chosen by the control decoder.
  typedef enum logic [1:0] {
    LANE_UPD = 2'd0,
    LANE_KEEP = 2'd1,
    LANE_CLR = 2'd2
  } lane_op_e;

  // Number of active lanes for a length code; code 3 aliases the full length.
  function automatic int unsigned active_lanes(input logic [1:0] code,
                                               input int unsigned lanes);
    int unsigned n;
    case (code)
      2'd0: n = lanes / 4;
      2'd1: n = lanes / 2;
      default: n = lanes;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dpacc_rst_sync.sv
module dpacc_rst_sync #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpacc_lane_ctl.sv
module dpacc_lane_ctl
  import dpacc_pkg::*;
#(
  parameter int LANES = 16
) (
  input logic [1:0] vlen_sel,
  input logic [LANES-1:0] lane_mask,
  input logic mask_on,
  input logic zero_mode,
  output lane_op_e [LANES-1:0] lane_op
);
  int unsigned act_cnt;

  always_comb begin
    act_cnt = active_lanes(vlen_sel, LANES);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_ctl
    always_comb begin
      if (i >= act_cnt) begin
        lane_op[i] = LANE_CLR;
      end else if (!mask_on || lane_mask[i]) begin
        lane_op[i] = LANE_UPD;
      end else if (zero_mode) begin
        lane_op[i] = LANE_CLR;
      end else begin
        lane_op[i] = LANE_KEEP;
      end
    end
  end
endmodule

// File: rtl/dpacc_lane.sv
module dpacc_lane
  import dpacc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANE_W = 2 * WORD_W
) (
  input logic [LANE_W-1:0] a_pair,
  input logic [LANE_W-1:0] b_pair,
  input logic [LANE_W-1:0] acc,
  input lane_op_e op,
  output logic [LANE_W-1:0] res
);
  localparam int PROD_W = 2 * WORD_W;

  logic signed [WORD_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic signed [PROD_W-1:0] prod_lo, prod_hi;
  logic [LANE_W-1:0] prod_lo_x, prod_hi_x;
  logic [LANE_W-1:0] dot_sum;

  always_comb begin
    a_lo = a_pair[WORD_W-1:0];
    a_hi = a_pair[2*WORD_W-1:WORD_W];
    b_lo = b_pair[WORD_W-1:0];
    b_hi = b_pair[2*WORD_W-1:WORD_W];
    prod_lo = a_lo * b_lo;
    prod_hi = a_hi * b_hi;
    prod_lo_x = LANE_W'(prod_lo);
    prod_hi_x = LANE_W'(prod_hi);
    dot_sum = acc + prod_lo_x + prod_hi_x;
  end

  always_comb begin
    case (op)
      LANE_UPD: res = dot_sum;
      LANE_KEEP: res = acc;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/dpacc_top.sv
module dpacc_top
  import dpacc_pkg::*;
#(
  parameter int VEC_W = 512,
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic [511:0] src_a,
  input logic [511:0] src_b,
  input logic [511:0] acc_in,
  input logic [1:0] vlen_sel,
  input logic [15:0] lane_mask,
  input logic mask_on,
  input logic zero_mode,
  input logic bcast,
  output logic out_valid,
  output logic [511:0] result
);
  localparam int LANE_W = 2 * WORD_W;
  localparam int LANES = VEC_W / LANE_W;

  logic rst_sync_n;
  lane_op_e [LANES-1:0] lane_op;
  logic [VEC_W-1:0] next_vec;
  logic [VEC_W-1:0] result_q;
  logic valid_q;

  dpacc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk),
    .rst_n(rst_n),
    .rst_sync_n(rst_sync_n)
  );

  dpacc_lane_ctl #(.LANES(LANES)) u_ctl (
    .vlen_sel(vlen_sel),
    .lane_mask(lane_mask),
    .mask_on(mask_on),
    .zero_mode(zero_mode),
    .lane_op(lane_op)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] b_sel;

    always_comb begin
      b_sel = bcast ? src_b[LANE_W-1:0] : src_b[i*LANE_W +: LANE_W];
    end

    dpacc_lane #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lane (
      .a_pair(src_a[i*LANE_W +: LANE_W]),
      .b_pair(b_sel),
      .acc(acc_in[i*LANE_W +: LANE_W]),
      .op(lane_op[i]),
      .res(next_vec[i*LANE_W +: LANE_W])
    );

    // R4: lanes past the active length come out zero.
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && (i >= active_lanes(vlen_sel, LANES)))
      |=> (result[i*LANE_W +: LANE_W] == '0));

    // R5: a masked active lane is cleared in zeroing mode.
    p_mask_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && mask_on && zero_mode && !lane_mask[i])
      |=> (result[i*LANE_W +: LANE_W] == '0));

    // R6: a masked active lane keeps its old value in merge mode.
    p_mask_merge_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && mask_on && !zero_mode && !lane_mask[i]
       && (i < active_lanes(vlen_sel, LANES)))
      |=> (result[i*LANE_W +: LANE_W] == $past(acc_in[i*LANE_W +: LANE_W])));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
    end else if (in_valid) begin
      result_q <= next_vec;
    end
  end

  assign out_valid = valid_q;
  assign result = result_q;

  // R9: the valid flag trails the strobe by exactly one cycle.
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  // R9: without a strobe the result holds.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(result));
  // R10: nothing is valid while reset is applied.
  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

// File: tb/tb_dpacc_top.sv
module tb_dpacc_top;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [511:0] src_a, src_b, acc_in;
  logic [1:0] vlen_sel;
  logic [15:0] lane_mask;
  logic mask_on, zero_mode, bcast;
  logic out_valid;
  logic [511:0] result;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dpacc_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .vlen_sel(vlen_sel), .lane_mask(lane_mask), .mask_on(mask_on),
    .zero_mode(zero_mode), .bcast(bcast),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [511:0] model(
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] c,
    input logic [1:0] vl, input logic [15:0] m, input logic mon,
    input logic z, input logic bc);
    logic [511:0] r;
    int act;
    r = '0;
    act = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] bw;
      logic [31:0] old;
      longint s;
      bw = bc ? b[31:0] : b[32*i +: 32];
      old = c[32*i +: 32];
      if (i >= act) r[32*i +: 32] = 32'h0;
      else if (mon && !m[i]) r[32*i +: 32] = z ? 32'h0 : old;
      else begin
        s = longint'(signed'(old))
          + longint'(signed'(a[32*i +: 16])) * longint'(signed'(bw[15:0]))
          + longint'(signed'(a[32*i+16 +: 16])) * longint'(signed'(bw[31:16]));
        r[32*i +: 32] = s[31:0];
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [511:0] exp_v);
    n_checks++;
    if (out_valid !== 1'b1 || result !== exp_v) begin
      n_fail++;
      $display("FAIL %s valid=%b result=%h expected=%h", tag, out_valid, result, exp_v);
    end
  endtask

  task automatic apply(input string tag);
    logic [511:0] e;
    e = model(src_a, src_b, acc_in, vlen_sel, lane_mask, mask_on, zero_mode, bcast);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, e);
  endtask

  task automatic set_ops(input logic [1:0] vl, input logic [15:0] m,
                         input logic mon, input logic z, input logic bc);
    vlen_sel = vl; lane_mask = m; mask_on = mon; zero_mode = z; bcast = bc;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0;
    src_a = '0; src_b = '0; acc_in = '0;
    set_ops(2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R10 reset state
    n_checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_fail++;
      $display("FAIL R10 valid=%b result=%h expected 0/0", out_valid, result);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_fail++;
      $display("FAIL R10 after release valid=%b result=%h expected 0/0", out_valid, result);
    end

    // R1: distinct per-word operands, no masking
    for (int i = 0; i < 32; i++) begin
      src_a[16*i +: 16] = 16'(i + 1);
      src_b[16*i +: 16] = 16'(3 - i);
    end
    acc_in = rnd512();
    set_ops(2'd2, 16'h0000, 1'b0, 1'b1, 1'b0);
    apply("R1 R7 word pairing");

    // R2: extreme products with a large accumulator, wrap
    for (int i = 0; i < 16; i++) begin
      src_a[32*i +: 32] = 32'h8000_8000;
      src_b[32*i +: 32] = 32'h8000_8000;
      acc_in[32*i +: 32] = 32'h7FFF_0000;
    end
    set_ops(2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    apply("R2 wrap");
    n_checks++;
    if (result[31:0] !== 32'hFFFF_0000) begin
      n_fail++;
      $display("FAIL R2 lane0=%h expected=%h", result[31:0], 32'hFFFF_0000);
    end

    // R3/R4: every length code with all-ones style data
    for (int v = 0; v < 4; v++) begin
      src_a = rnd512(); src_b = rnd512(); acc_in = {16{32'hFFFF_FFFF}};
      set_ops(2'(v), 16'hFFFF, 1'b0, 1'b0, 1'b0);
      apply("R3 R4 length code");
    end

    // R5 zeroing mask, R6 merge mask
    src_a = rnd512(); src_b = rnd512(); acc_in = rnd512();
    set_ops(2'd2, 16'hA5C3, 1'b1, 1'b1, 1'b0);
    apply("R5 zeroing");
    set_ops(2'd2, 16'h3C5A, 1'b1, 1'b0, 1'b0);
    apply("R6 merge");
    set_ops(2'd1, 16'h0000, 1'b1, 1'b0, 1'b0);
    apply("R6 R4 merge all masked");

    // R8 broadcast, upper src_b bits differ from lane 0
    src_b = rnd512();
    src_b[31:0] = 32'h8001_7FFF;
    set_ops(2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    apply("R8 broadcast");

    // R9 hold: inputs change while strobe low
    held = result;
    src_a = rnd512(); acc_in = rnd512();
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== held) begin
      n_fail++;
      $display("FAIL R9 valid=%b result=%h expected=%h", out_valid, result, held);
    end

    // Random mix, R1 R2 R3 R4 R5 R6 R7 R8
    for (int t = 0; t < 400; t++) begin
      logic [2:0] mp;
      src_a = rnd512(); src_b = rnd512(); acc_in = rnd512();
      mp = 3'($urandom_range(0, 4));
      set_ops(2'($urandom_range(0, 3)),
              (mp == 0) ? 16'hFFFF : (mp == 1) ? 16'h0000 : 16'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom));
      if (t % 7 == 0) src_a[31:0] = 32'h8000_8000;
      if (t % 7 == 0) src_b[31:0] = 32'h8000_8000;
      apply("R2 random");
      if (t % 5 == 0) @(negedge clk);
    end

    finish_run();
  end
endmodule